// File: doc/BRIEF.md
# Paired Polynomial Sine and Cosine Generator

This block turns a 16-bit unsigned phase into its sine and its cosine, both as signed Q15 words. One full turn is 2^16 phase counts. The top two phase bits select the quadrant. The remaining fourteen bits become a first-quadrant argument `u` in [0, 1), in units of a quarter turn.

Two odd and even polynomials in `u` are evaluated in Horner form:
- sine: `u*(a1 + z*(a3 + z*(a5 + z*a7)))`
- cosine: `c0 + z*(c2 + z*(c4 + z*c6))`
- both use `z = u*u`.

The two results are then swapped and negated according to the quadrant.

All multiplies share one pipelined multiplier with a configurable number of stages. The sine chain issues one multiply and then waits for its product. The cosine chain issues its own multiplies in the cycle right after each sine issue, which fills the otherwise idle slots. As a result the cosine costs no extra latency, and both values appear together with one ready pulse.

A client pulses a request with a phase whenever the busy flag is low, including the cycle of the ready pulse. It then reads both outputs in the ready cycle. The outputs hold until the next ready pulse.

Top module: `sincos_poly`

## Requirements
- R1: For phases 0x0000, 0x4000, 0x8000 and 0xC000, (sine, cosine) equal exactly (0, 32767), (32767, 0), (0, -32767) and (-32767, 0).
- R2: For every phase a, sine is within 16 of round(32767*sin(2*pi*a/65536)), and cosine is within 16 of round(32767*cos(2*pi*a/65536)).
- R3: Neither output ever takes the value -32768; the magnitudes are clamped to 32767.
- R4: The quadrant is taken from phase bits [15:14]. For any phase a, sine(a+0x4000) equals cosine(a) exactly, and cosine(a+0x4000) equals -sine(a) exactly.
- R5: ready_o is a single-cycle pulse, first high 5*MUL_LAT+1 clock edges after the edge that accepted the request. Both outputs change only in a ready cycle.
- R6: busy_o is high from the cycle after acceptance up to, but not including, the ready cycle. A request while busy_o is high is ignored: it causes no extra ready pulse and does not change the result of the request in flight.
- R7: A request presented in the ready cycle (busy_o low) is accepted; busy_o is high in the following cycle.
- R8: The shared multiplier receives at most one issue per cycle, and the cosine chain completes before the sine chain finishes.
- R9: During reset, busy_o and ready_o are 0 and both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request strobe, taken when busy_o is low |
| angle_i | input | ANGLE_W | Unsigned phase, 2^ANGLE_W counts per turn |
| busy_o | output | 1 | Computation in flight |
| ready_o | output | 1 | One-cycle pulse: outputs are new |
| sine_o | output | OUT_W | Signed Q15 sine |
| cosine_o | output | OUT_W | Signed Q15 cosine |

## Verification
The hardest condition to reach from the ports is a new request in the exact cycle of the previous ready pulse. That cycle is the only moment the block goes idle and is reloaded at the same edge.

The sweep over 4096 evenly spaced phases issues every request in the preceding ready cycle. Acceptance at that boundary is therefore exercised thousands of times. A separate run holds the request high through the busy window with a different phase, to show that it is ignored.

The quadrant symmetry is checked by pairing stored results a quarter turn apart. That comparison is exact, so a single wrong swap or sign is exposed.

// File: rtl/sc_pkg.sv
package sc_pkg;
  // internal datapath: signed, CW bits, CF fractional bits
  localparam int CW = 20;
  localparam int CF = 16;

  // sine coefficients (odd powers of u), Q16
  localparam logic signed [CW-1:0] SA1 = 20'sd102944;
  localparam logic signed [CW-1:0] SA3 = -20'sd42334;
  localparam logic signed [CW-1:0] SA5 = 20'sd5223;
  localparam logic signed [CW-1:0] SA7 = -20'sd296;

  // cosine coefficients (even powers of u), Q16
  localparam logic signed [CW-1:0] SC0 = 20'sd65536;
  localparam logic signed [CW-1:0] SC2 = -20'sd80852;
  localparam logic signed [CW-1:0] SC4 = 20'sd16624;
  localparam logic signed [CW-1:0] SC6 = -20'sd1307;
endpackage

// File: rtl/sc_pipe_mul.sv
module sc_pipe_mul #(
  parameter int W   = 20,
  parameter int F   = 16,
  parameter int LAT = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_vld,
  input  logic                in_tag,
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  output logic                out_vld,
  output logic                out_tag,
  output logic signed [W-1:0] p
);
  localparam int PW = 2 * W;
  localparam logic signed [PW-1:0] RND = PW'(1) <<< (F - 1);

  logic [LAT-1:0]      vld_q;
  logic [LAT-1:0]      tag_q;
  logic signed [W-1:0] p_q [LAT];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      tag_q <= '0;
    end else begin
      vld_q <= {vld_q[LAT-2:0], in_vld};
      tag_q <= {tag_q[LAT-2:0], in_tag};
    end
  end

  always_ff @(posedge clk) begin
    p_q[0] <= W'((PW'(a) * PW'(b) + RND) >>> F);
    for (int i = 1; i < LAT; i++) p_q[i] <= p_q[i-1];
  end

  assign out_vld = vld_q[LAT-1];
  assign out_tag = tag_q[LAT-1];
  assign p       = p_q[LAT-1];
endmodule

// File: rtl/sc_fold.sv
module sc_fold #(
  parameter int ANGLE_W = 16,
  parameter int W       = 20,
  parameter int F       = 16
) (
  input  logic [ANGLE_W-1:0]  angle,
  output logic [1:0]          quad,
  output logic signed [W-1:0] u
);
  localparam int RW  = ANGLE_W - 2;
  localparam int PAD = F - RW;

  assign quad = angle[ANGLE_W-1 -: 2];
  assign u    = {{(W - F){1'b0}}, angle[RW-1:0], {PAD{1'b0}}};
endmodule

// File: rtl/sc_unfold.sv
module sc_unfold #(
  parameter int W     = 20,
  parameter int F     = 16,
  parameter int OUT_W = 16
) (
  input  logic signed [W-1:0]     s_in,
  input  logic signed [W-1:0]     c_in,
  input  logic [1:0]              quad,
  output logic signed [OUT_W-1:0] sine,
  output logic signed [OUT_W-1:0] cosine
);
  localparam int SH = F - OUT_W + 1;
  localparam logic signed [W-1:0] HALF = W'(1) <<< (SH - 1);
  localparam logic signed [W-1:0] MAXV = W'((1 <<< (OUT_W - 1)) - 1);

  function automatic logic signed [OUT_W-1:0] to_mag(input logic signed [W-1:0] x);
    logic signed [W-1:0] t;
    t = (x + HALF) >>> SH;
    if (t < 0) return '0;
    if (t > MAXV) return MAXV[OUT_W-1:0];
    return t[OUT_W-1:0];
  endfunction

  logic signed [OUT_W-1:0] ms, mc;

  always_comb begin
    ms = to_mag(s_in);
    mc = to_mag(c_in);
    case (quad)
      2'd0:    begin sine = ms;  cosine = mc;  end
      2'd1:    begin sine = mc;  cosine = -ms; end
      2'd2:    begin sine = -ms; cosine = -mc; end
      default: begin sine = -mc; cosine = ms;  end
    endcase
  end
endmodule

// File: rtl/sincos_poly.sv
module sincos_poly #(
  parameter int MUL_LAT = 3,
  parameter int ANGLE_W = 16,
  parameter int OUT_W   = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_i,
  input  logic [ANGLE_W-1:0]       angle_i,
  output logic                     busy_o,
  output logic                     ready_o,
  output logic signed [OUT_W-1:0]  sine_o,
  output logic signed [OUT_W-1:0]  cosine_o
);
  import sc_pkg::*;
  localparam int W = CW;
  localparam int F = CF;
  localparam logic [2:0] KS_LAST = 3'd4;
  localparam logic [1:0] KC_LAST = 2'd3;

  logic                busy_q, launch_q, cos_go_q, cdone_q;
  logic [2:0]          ks_q;
  logic [1:0]          kc_q, quad_q;
  logic signed [W-1:0] u_q, z_q, cres_q;

  logic [1:0]          f_quad;
  logic signed [W-1:0] f_u;
  logic                m_vld, m_tag, r_vld, r_tag;
  logic signed [W-1:0] m_a, m_b, r_p;
  logic signed [OUT_W-1:0] uf_s, uf_c;

  logic ret_s, ret_c, fin, is_l, is_s, is_g, is_c;

  sc_fold #(.ANGLE_W(ANGLE_W), .W(W), .F(F)) i_fold (
    .angle(angle_i), .quad(f_quad), .u(f_u)
  );

  sc_pipe_mul #(.W(W), .F(F), .LAT(MUL_LAT)) i_mul (
    .clk(clk), .rst(rst), .in_vld(m_vld), .in_tag(m_tag), .a(m_a), .b(m_b),
    .out_vld(r_vld), .out_tag(r_tag), .p(r_p)
  );

  sc_unfold #(.W(W), .F(F), .OUT_W(OUT_W)) i_unfold (
    .s_in(r_p), .c_in(cres_q), .quad(quad_q), .sine(uf_s), .cosine(uf_c)
  );

  // issue scheduling: sine issues on its own returns, cosine one cycle later
  always_comb begin
    ret_s = r_vld && !r_tag;
    ret_c = r_vld && r_tag;
    fin   = ret_s && (ks_q == KS_LAST);
    is_l  = launch_q;
    is_s  = ret_s && (ks_q != KS_LAST);
    is_g  = cos_go_q;
    is_c  = ret_c && (kc_q != KC_LAST);
    m_vld = is_l || is_s || is_g || is_c;
    m_tag = 1'b0;
    m_a   = z_q;
    m_b   = '0;
    if (is_l) begin
      m_a = u_q;
      m_b = u_q;
    end else if (is_s) begin
      case (ks_q)
        3'd0:    begin m_a = r_p; m_b = SA7;       end
        3'd1:    begin m_a = z_q; m_b = r_p + SA5; end
        3'd2:    begin m_a = z_q; m_b = r_p + SA3; end
        default: begin m_a = u_q; m_b = r_p + SA1; end
      endcase
    end else if (is_g) begin
      m_tag = 1'b1;
      m_b   = SC6;
    end else if (is_c) begin
      m_tag = 1'b1;
      m_b   = (kc_q == 2'd1) ? r_p + SC4 : r_p + SC2;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      launch_q <= 1'b0;
      cos_go_q <= 1'b0;
      cdone_q  <= 1'b0;
      ks_q     <= '0;
      kc_q     <= '0;
      quad_q   <= '0;
      u_q      <= '0;
      z_q      <= '0;
      cres_q   <= '0;
      ready_o  <= 1'b0;
      sine_o   <= '0;
      cosine_o <= '0;
    end else begin
      ready_o  <= 1'b0;
      launch_q <= 1'b0;
      if (req_i && !busy_q) begin
        busy_q   <= 1'b1;
        launch_q <= 1'b1;
        u_q      <= f_u;
        quad_q   <= f_quad;
        ks_q     <= '0;
        cdone_q  <= 1'b0;
      end
      if (ret_s) begin
        if (ks_q == 3'd0) begin
          z_q      <= r_p;
          cos_go_q <= 1'b1;
        end
        ks_q <= ks_q + 3'd1;
      end
      if (cos_go_q) begin
        cos_go_q <= 1'b0;
        kc_q     <= 2'd1;
      end
      if (ret_c) begin
        if (kc_q == KC_LAST) begin
          cres_q  <= r_p + SC0;
          cdone_q <= 1'b1;
        end else begin
          kc_q <= kc_q + 2'd1;
        end
      end
      if (fin) begin
        busy_q   <= 1'b0;
        ready_o  <= 1'b1;
        sine_o   <= uf_s;
        cosine_o <= uf_c;
      end
    end
  end

  assign busy_o = busy_q;

  AST_ONE_ISSUE: assert property (@(posedge clk) disable iff (rst)
    $countones({is_l, is_s, is_g, is_c}) <= 1); // R8
  AST_COS_FIRST: assert property (@(posedge clk) disable iff (rst)
    fin |-> cdone_q); // R8
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
    ready_o |=> !ready_o); // R5
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ready_o |-> ($stable(sine_o) && $stable(cosine_o))); // R5
  AST_BUSY_DROP: assert property (@(posedge clk) disable iff (rst)
    ready_o |-> (!busy_o && $past(busy_o))); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (sine_o != {1'b1, {(OUT_W-1){1'b0}}}) && (cosine_o != {1'b1, {(OUT_W-1){1'b0}}})); // R3
endmodule

// File: tb/test_sincos_poly.sv
module test_sincos_poly;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 3;
  localparam int EXP_LAT    = 5 * LAT + 1;
  localparam int TOL        = 16;
  localparam int STRIDE     = 16;
  localparam int N          = 65536 / STRIDE;
  localparam real TWO_PI    = 6.283185307179586;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0;
  logic [15:0] ang = '0;
  logic busy, ready;
  logic signed [15:0] sine, cosine;

  int checks = 0;
  int fails  = 0;
  logic signed [15:0] s_tab [N];
  logic signed [15:0] c_tab [N];

  sincos_poly #(.MUL_LAT(LAT)) i_sincos_poly (
    .clk(clk), .rst(rst), .req_i(req), .angle_i(ang),
    .busy_o(busy), .ready_o(ready), .sine_o(sine), .cosine_o(cosine)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  function automatic int rnd(input real x);
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
  endfunction

  // called at a negedge; returns at the negedge of the ready cycle
  task automatic run(input logic [15:0] a, input bit after_ready);
    int cnt;
    req = 1'b1;
    ang = a;
    @(negedge clk);
    req = 1'b0;
    if (after_ready) chk(busy == 1'b1, "R7 busy after accept in ready cycle", int'(busy), 1);
    cnt = 0;
    while (!ready && cnt < 100) begin
      @(negedge clk);
      cnt++;
    end
    chk(cnt == EXP_LAT, "R5 ready latency", cnt, EXP_LAT);
    chk(busy == 1'b0, "R6 busy low in ready cycle", int'(busy), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(busy == 1'b0 && ready == 1'b0, "R9 reset flags", int'({busy, ready}), 0);
    chk(sine == 0 && cosine == 0, "R9 reset outputs", int'(sine), 0);
    rst = 1'b0;
    @(negedge clk);

    // sweep: back-to-back requests, each issued in the previous ready cycle
    for (int i = 0; i < N; i++) begin
      run(16'(i * STRIDE), i != 0);
      s_tab[i] = sine;
      c_tab[i] = cosine;
    end

    for (int i = 0; i < N; i++) begin
      real th;
      int es, ec;
      th = TWO_PI * real'(i * STRIDE) / 65536.0;
      es = rnd(32767.0 * $sin(th));
      ec = rnd(32767.0 * $cos(th));
      chk((int'(s_tab[i]) - es <= TOL) && (es - int'(s_tab[i]) <= TOL), "R2 sine accuracy", int'(s_tab[i]), es);
      chk((int'(c_tab[i]) - ec <= TOL) && (ec - int'(c_tab[i]) <= TOL), "R2 cosine accuracy", int'(c_tab[i]), ec);
      chk(s_tab[i] != -16'sd32768 && c_tab[i] != -16'sd32768, "R3 no negative full scale", int'(s_tab[i]), int'(c_tab[i]));
    end

    // R1 exact quadrant boundaries
    chk(s_tab[0] == 0 && c_tab[0] == 32767, "R1 phase 0x0000 cos", int'(c_tab[0]), 32767);
    chk(s_tab[N/4] == 32767 && c_tab[N/4] == 0, "R1 phase 0x4000 sin", int'(s_tab[N/4]), 32767);
    chk(s_tab[N/2] == 0 && c_tab[N/2] == -32767, "R1 phase 0x8000 cos", int'(c_tab[N/2]), -32767);
    chk(s_tab[3*N/4] == -32767 && c_tab[3*N/4] == 0, "R1 phase 0xC000 sin", int'(s_tab[3*N/4]), -32767);

    // R4 exact quarter-turn symmetry
    for (int i = 0; i < N; i++) begin
      int j;
      j = (i + N/4) % N;
      chk(s_tab[j] == c_tab[i], "R4 sin(a+q)==cos(a)", int'(s_tab[j]), int'(c_tab[i]));
      chk(c_tab[j] == -c_tab[i] * 0 - s_tab[i], "R4 cos(a+q)==-sin(a)", int'(c_tab[j]), -int'(s_tab[i]));
    end

    // R6: requests while busy are ignored
    @(negedge clk);
    req = 1'b1;
    ang = 16'h1000;
    @(negedge clk);
    ang = 16'h3000;
    begin
      int cnt;
      int extra;
      cnt = 0;
      while (!ready && cnt < 100) begin
        if (cnt == 5) req = 1'b0;
        chk(busy == 1'b1, "R6 busy while computing", int'(busy), 1);
        @(negedge clk);
        cnt++;
      end
      req = 1'b0;
      chk(cnt == EXP_LAT, "R6 latency with ignored requests", cnt, EXP_LAT);
      chk(sine == s_tab[16'h1000 / STRIDE], "R6 sine from first request", int'(sine), int'(s_tab[16'h1000 / STRIDE]));
      chk(cosine == c_tab[16'h1000 / STRIDE], "R6 cosine from first request", int'(cosine), int'(c_tab[16'h1000 / STRIDE]));
      @(negedge clk);
      chk(ready == 1'b0, "R5 ready one cycle", int'(ready), 0);
      extra = 0;
      for (int k = 0; k < 3 * EXP_LAT; k++) begin
        if (ready) extra++;
        @(negedge clk);
      end
      chk(extra == 0, "R6 no extra ready", extra, 0);
      chk(sine == s_tab[16'h1000 / STRIDE], "R5 outputs hold", int'(sine), int'(s_tab[16'h1000 / STRIDE]));
    end

    summary();
    $finish;
  end
endmodule